// File: doc/BRIEF.md
# Triple-Redundant Serial Command Decoder

This block turns a one-bit serial command line, sampled once per clock, into decoded actions. A command opens with the first `1` seen while the decoder is idle. That bit is the first of a 5-bit class header, and all fields are sent most significant bit first. One header class is a level-1 trigger on its own. The other header leads into a 4-bit field. That field selects one of three fast commands (bunch-counter reset, event-counter reset, calibration) or announces a slow command. A slow command carries an opcode, a 4-bit chip identifier and, depending on the opcode, a register address, write data or a pulse width.

A run-mode flag gates triggers and fast commands. Only a slow command sets the flag, and only a slow command clears it. Every stored bit of the decoder, including the flag, the partial fields and the error counter, is held in three replicas. The replicas are majority-voted each clock. Any disagreement between replicas is counted in a saturating 5-bit counter. Results leave the block as one-clock strobes, plus the address, write data and pulse width that go with them. Register storage lies outside the block.

Top module: `cmd_decoder_tmr`

## Requirements
- R1: While `rst_n` is low at a clock edge, the decoder goes idle: run mode 0, error counter 0, no strobe and no pulse.
- R2: With run mode on, the header `11101` makes `trig_o` high for exactly the one clock that follows the edge sampling the header's last bit, with `trig_flip_o` low.
- R3: A header that starts with `1` and differs from `11101` in exactly one of its four later bits still produces the trigger strobe, and `trig_flip_o` is high in that same clock.
- R4: With run mode on, header `10110` followed by field `0001`, `0010` or `0100` strobes `bcr_o`, `ecr_o` or `cal_o` respectively, one clock after the last field bit.
- R5: With run mode off, triggers and fast commands produce no strobe. Slow commands are always accepted.
- R6: Header `10110`, field `1000`, then a 4-bit opcode and a 4-bit chip ID form a slow command. The ID matches when it equals `chip_id_i` or when its top bit is 1. Opcode `1010` sets run mode. Opcode `1000` strobes `greset_o`, clears run mode and ends any pulse in progress.
- R7: Opcode `0001` followed by a 6-bit address strobes `rd_o` with `reg_addr_o` equal to that address.
- R8: Opcode `0010` followed by a 6-bit address and 16 data bits strobes `wr_o` with `reg_addr_o` and `wr_data_o` equal to those fields.
- R9: Opcode `1001` followed by a 6-bit width w drives `gpulse_o` high for w+1 consecutive clocks, with `pulse_width_o` equal to w.
- R10: A slow command whose ID does not match is read to its last bit and then dropped without any strobe, so its payload bits are never taken as a new command.
- R11: A header that is neither class, an unknown fast field or an unknown opcode returns the decoder to idle with no strobe and no reset. The next command is then decoded normally.
- R12: A single corrupted replica is outvoted, so the outputs are unaffected. Every clock with disagreeing replicas increments `flip_count_o`, which holds at 31.
- R13: At most one of the command strobes is high in any clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock; one serial bit per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_i | input | 1 | Serial command line, MSB first |
| chip_id_i | input | 4 | Local chip identifier |
| trig_o | output | 1 | Level-1 trigger strobe |
| trig_flip_o | output | 1 | Trigger header carried one flipped bit |
| bcr_o | output | 1 | Bunch-counter reset strobe |
| ecr_o | output | 1 | Event-counter reset strobe |
| cal_o | output | 1 | Calibration strobe |
| rd_o | output | 1 | Register read strobe |
| wr_o | output | 1 | Register write strobe |
| reg_addr_o | output | 6 | Address of the latest read or write |
| wr_data_o | output | 16 | Data of the latest write |
| greset_o | output | 1 | Global reset strobe |
| gpulse_o | output | 1 | Global pulse level |
| pulse_width_o | output | 6 | Width field of the latest accepted pulse |
| run_mode_o | output | 1 | Run-mode flag |
| flip_count_o | output | 5 | Saturating replica-disagreement counter |

## Verification
The bench sends every one-bit variant of the trigger header; a decoder that compared exactly would drop them, and one that ignored the flag would report them as clean. Bad headers, fields and opcodes are each followed at once by a valid command, which exposes a state machine that stays stuck or mis-frames the next bit. A non-matching write carries payload that contains the trigger pattern, so a parser that stopped early would emit a stray trigger. Pulses of width 0, 5 and 63 catch an off-by-one in the length. Forcing one replica to zero tests masking, the counter step and saturation at 31. A counter that wrapped would read a small value instead of 31.

// File: rtl/cmd_dec_pkg.sv
// Shared constants and state types for the serial command decoder.
// Assumes MSB-first fields and one command bit per clock.
package cmd_dec_pkg;
    localparam int HDR_W   = 5;
    localparam int CODE_W  = 4;
    localparam int ID_W    = 4;
    localparam int ADDR_W  = 6;
    localparam int DATA_W  = 16;
    localparam int WID_W   = 6;
    localparam int ERR_W   = 5;
    localparam int CNT_W   = $clog2(DATA_W) + 1;
    localparam int PCNT_W  = WID_W + 1;
    localparam int SH_W    = DATA_W;
    localparam int N_REP   = 3;

    localparam logic [HDR_W-1:0]  HDR_TRIG = 5'b11101;
    localparam logic [HDR_W-1:0]  HDR_CMD  = 5'b10110;
    localparam logic [CODE_W-1:0] FC_BCR   = 4'b0001;
    localparam logic [CODE_W-1:0] FC_ECR   = 4'b0010;
    localparam logic [CODE_W-1:0] FC_CAL   = 4'b0100;
    localparam logic [CODE_W-1:0] FC_SLOW  = 4'b1000;
    localparam logic [CODE_W-1:0] SC_RD    = 4'b0001;
    localparam logic [CODE_W-1:0] SC_WR    = 4'b0010;
    localparam logic [CODE_W-1:0] SC_GRST  = 4'b1000;
    localparam logic [CODE_W-1:0] SC_PULSE = 4'b1001;
    localparam logic [CODE_W-1:0] SC_RUN   = 4'b1010;

    typedef enum logic [2:0] {
        PH_IDLE, PH_HDR, PH_FAST, PH_OPC, PH_CHIP, PH_ADDR, PH_DATA, PH_WIDTH
    } phase_e;

    typedef struct packed {
        logic trig;
        logic tflip;
        logic bcr;
        logic ecr;
        logic cal;
        logic rd;
        logic wr;
        logic grst;
    } strobe_t;

    typedef struct packed {
        phase_e              phase;
        logic [CNT_W-1:0]    cnt;
        logic [SH_W-1:0]     sh;
        logic [CODE_W-1:0]   opc;
        logic                hit;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   wdata;
        logic [WID_W-1:0]    pwidth;
        logic [PCNT_W-1:0]   pcnt;
        logic                run;
        logic [ERR_W-1:0]    errs;
        strobe_t             stb;
    } dec_state_t;
endpackage

// File: rtl/cmd_tmr_reg.sv
// One replica of the decoder state register.
// Assumes the all-zero word is the idle state.
module cmd_tmr_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    // Load the voted next state, or clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q_o <= '0;
        else        q_o <= d_i;
    end
endmodule

// File: rtl/cmd_vote.sv
// Bitwise two-of-three majority voter with a disagreement flag.
// Assumes at most one replica is corrupted at a time.
module cmd_vote #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [W-1:0] c_i,
    output logic [W-1:0] vote_o,
    output logic         mismatch_o
);
    // Majority of each bit position.
    always_comb vote_o = (a_i & b_i) | (b_i & c_i) | (a_i & c_i);
    // Any bit where the three replicas are not identical.
    always_comb mismatch_o = (a_i != b_i) || (b_i != c_i);
endmodule

// File: rtl/cmd_next.sv
// Next-state logic: shifts in one command bit per clock, frames fields
// by phase and bit count, and raises strobes on completed commands.
// Assumes cur_i is the voted state.
module cmd_next
    import cmd_dec_pkg::*;
(
    input  dec_state_t        cur_i,
    input  logic              bit_i,
    input  logic [ID_W-1:0]   chip_id_i,
    input  logic              mismatch_i,
    output dec_state_t        nxt_o
);
    localparam logic [CNT_W-1:0] LAST_HDR  = CNT_W'(HDR_W - 1);
    localparam logic [CNT_W-1:0] LAST_CODE = CNT_W'(CODE_W - 1);
    localparam logic [CNT_W-1:0] LAST_ADDR = CNT_W'(ADDR_W - 1);
    localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] LAST_WID  = CNT_W'(WID_W - 1);

    logic [SH_W-1:0]   sh_n;
    logic [HDR_W-1:0]  hdr;
    logic [CODE_W-1:0] code;
    logic              id_hit;

    // Field views of the shift register including the incoming bit.
    always_comb begin
        sh_n   = {cur_i.sh[SH_W-2:0], bit_i};
        hdr    = sh_n[HDR_W-1:0];
        code   = sh_n[CODE_W-1:0];
        id_hit = (code == chip_id_i) || code[ID_W-1];
    end

    // Phase sequencing and command execution.
    always_comb begin
        nxt_o     = cur_i;
        nxt_o.stb = '0;
        nxt_o.sh  = sh_n;
        nxt_o.cnt = cur_i.cnt + 1'b1;
        if (cur_i.pcnt != '0) nxt_o.pcnt = cur_i.pcnt - 1'b1;
        if (mismatch_i && (cur_i.errs != '1)) nxt_o.errs = cur_i.errs + 1'b1;
        case (cur_i.phase)
            PH_IDLE: begin
                nxt_o.cnt = CNT_W'(bit_i);
                if (bit_i) nxt_o.phase = PH_HDR;
            end
            PH_HDR: if (cur_i.cnt == LAST_HDR) begin
                nxt_o.cnt   = '0;
                nxt_o.phase = PH_IDLE;
                if (hdr == HDR_CMD) begin
                    nxt_o.phase = PH_FAST;
                end else if ($countones(hdr ^ HDR_TRIG) <= 1 && cur_i.run) begin
                    nxt_o.stb.trig  = 1'b1;
                    nxt_o.stb.tflip = (hdr != HDR_TRIG);
                end
            end
            PH_FAST: if (cur_i.cnt == LAST_CODE) begin
                nxt_o.cnt   = '0;
                nxt_o.phase = PH_IDLE;
                case (code)
                    FC_BCR:  nxt_o.stb.bcr = cur_i.run;
                    FC_ECR:  nxt_o.stb.ecr = cur_i.run;
                    FC_CAL:  nxt_o.stb.cal = cur_i.run;
                    FC_SLOW: nxt_o.phase = PH_OPC;
                    default: nxt_o.phase = PH_IDLE;
                endcase
            end
            PH_OPC: if (cur_i.cnt == LAST_CODE) begin
                nxt_o.cnt   = '0;
                nxt_o.opc   = code;
                nxt_o.phase = (code == SC_RD || code == SC_WR || code == SC_GRST ||
                               code == SC_PULSE || code == SC_RUN) ? PH_CHIP : PH_IDLE;
            end
            PH_CHIP: if (cur_i.cnt == LAST_CODE) begin
                nxt_o.cnt   = '0;
                nxt_o.hit   = id_hit;
                nxt_o.phase = PH_IDLE;
                case (cur_i.opc)
                    SC_RD, SC_WR: nxt_o.phase = PH_ADDR;
                    SC_PULSE:     nxt_o.phase = PH_WIDTH;
                    SC_GRST: if (id_hit) begin
                        nxt_o.stb.grst = 1'b1;
                        nxt_o.run      = 1'b0;
                        nxt_o.pcnt     = '0;
                    end
                    SC_RUN: if (id_hit) nxt_o.run = 1'b1;
                    default: nxt_o.phase = PH_IDLE;
                endcase
            end
            PH_ADDR: if (cur_i.cnt == LAST_ADDR) begin
                nxt_o.cnt  = '0;
                nxt_o.addr = sh_n[ADDR_W-1:0];
                if (cur_i.opc == SC_WR) begin
                    nxt_o.phase = PH_DATA;
                end else begin
                    nxt_o.phase  = PH_IDLE;
                    nxt_o.stb.rd = cur_i.hit;
                end
            end
            PH_DATA: if (cur_i.cnt == LAST_DATA) begin
                nxt_o.cnt    = '0;
                nxt_o.phase  = PH_IDLE;
                nxt_o.wdata  = sh_n[DATA_W-1:0];
                nxt_o.stb.wr = cur_i.hit;
            end
            PH_WIDTH: if (cur_i.cnt == LAST_WID) begin
                nxt_o.cnt   = '0;
                nxt_o.phase = PH_IDLE;
                if (cur_i.hit) begin
                    nxt_o.pwidth = sh_n[WID_W-1:0];
                    nxt_o.pcnt   = {1'b0, sh_n[WID_W-1:0]} + 1'b1;
                end
            end
            default: nxt_o.phase = PH_IDLE;
        endcase
    end
endmodule

// File: rtl/cmd_decoder_tmr.sv
// Top level: three state replicas, a majority voter and shared next-state
// logic fed from the voted state. Assumes a single upset per clock.
module cmd_decoder_tmr
    import cmd_dec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_i,
    input  logic [ID_W-1:0]   chip_id_i,
    output logic              trig_o,
    output logic              trig_flip_o,
    output logic              bcr_o,
    output logic              ecr_o,
    output logic              cal_o,
    output logic              rd_o,
    output logic              wr_o,
    output logic [ADDR_W-1:0] reg_addr_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              greset_o,
    output logic              gpulse_o,
    output logic [WID_W-1:0]  pulse_width_o,
    output logic              run_mode_o,
    output logic [ERR_W-1:0]  flip_count_o
);
    localparam int SW = $bits(dec_state_t);

    logic [SW-1:0] rep_q [N_REP];
    logic [SW-1:0] cur_bits;
    logic [SW-1:0] nxt_bits;
    logic          mism;
    dec_state_t    cur;
    dec_state_t    nxt;

    generate
        for (genvar g = 0; g < N_REP; g++) begin : g_rep
            cmd_tmr_reg #(.W(SW)) u_reg (
                .clk   (clk),
                .rst_n (rst_n),
                .d_i   (nxt_bits),
                .q_o   (rep_q[g])
            );
        end
    endgenerate

    cmd_vote #(.W(SW)) u_vote (
        .a_i        (rep_q[0]),
        .b_i        (rep_q[1]),
        .c_i        (rep_q[2]),
        .vote_o     (cur_bits),
        .mismatch_o (mism)
    );

    // Typed views of the voted and next state words.
    always_comb begin
        cur      = dec_state_t'(cur_bits);
        nxt_bits = SW'(nxt);
    end

    cmd_next u_next (
        .cur_i      (cur),
        .bit_i      (cmd_i),
        .chip_id_i  (chip_id_i),
        .mismatch_i (mism),
        .nxt_o      (nxt)
    );

    // Outputs come straight from the voted state.
    always_comb begin
        trig_o        = cur.stb.trig;
        trig_flip_o   = cur.stb.tflip;
        bcr_o         = cur.stb.bcr;
        ecr_o         = cur.stb.ecr;
        cal_o         = cur.stb.cal;
        rd_o          = cur.stb.rd;
        wr_o          = cur.stb.wr;
        greset_o      = cur.stb.grst;
        reg_addr_o    = cur.addr;
        wr_data_o     = cur.wdata;
        gpulse_o      = (cur.pcnt != '0);
        pulse_width_o = cur.pwidth;
        run_mode_o    = cur.run;
        flip_count_o  = cur.errs;
    end
endmodule

// File: rtl/cmd_decoder_tmr_chk.sv
// Temporal checks on the decoder ports, bound into every instance.
module cmd_decoder_tmr_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       trig_o,
    input logic       trig_flip_o,
    input logic       bcr_o,
    input logic       ecr_o,
    input logic       cal_o,
    input logic       rd_o,
    input logic       wr_o,
    input logic       greset_o,
    input logic       gpulse_o,
    input logic       run_mode_o,
    input logic [4:0] flip_count_o
);
    AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({trig_o, bcr_o, ecr_o, cal_o, rd_o, wr_o, greset_o})); // R13
    AST_TRIG_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |-> run_mode_o); // R5
    AST_FAST_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (bcr_o || ecr_o || cal_o) |-> run_mode_o); // R5
    AST_FLAG_WITH_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
        trig_flip_o |-> trig_o); // R3
    AST_RUN_CLEARED_BY_GRST: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $fell(run_mode_o)) |-> greset_o); // R6
    AST_GRST_ENDS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        greset_o |-> !gpulse_o); // R6
    AST_ERRS_NEVER_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (flip_count_o >= $past(flip_count_o))); // R12
    AST_ERRS_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(flip_count_o) == 5'd31) |-> flip_count_o == 5'd31); // R12
endmodule

bind cmd_decoder_tmr cmd_decoder_tmr_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .trig_o       (trig_o),
    .trig_flip_o  (trig_flip_o),
    .bcr_o        (bcr_o),
    .ecr_o        (ecr_o),
    .cal_o        (cal_o),
    .rd_o         (rd_o),
    .wr_o         (wr_o),
    .greset_o     (greset_o),
    .gpulse_o     (gpulse_o),
    .run_mode_o   (run_mode_o),
    .flip_count_o (flip_count_o)
);

// File: tb/test_cmd_decoder_tmr.sv
// Scoreboard bench: the driver queues expected events before sending each
// command; a negedge monitor pops and compares every observed event.
module test_cmd_decoder_tmr;
    localparam int K_TRIG = 1, K_BCR = 2, K_ECR = 3, K_CAL = 4, K_RD = 5,
                   K_WR = 6, K_GRST = 7, K_PULSE = 8;
    localparam logic [4:0] H_TRIG = 5'b11101;
    localparam logic [4:0] H_CMD  = 5'b10110;
    localparam logic [3:0] MY_ID  = 4'h5;

    typedef struct { int kind; int a; int d; string req; } ev_t;

    logic clk = 1'b0, rst_n = 1'b0, cmd_i = 1'b0;
    logic [3:0] chip_id_i = MY_ID;
    logic trig_o, trig_flip_o, bcr_o, ecr_o, cal_o, rd_o, wr_o;
    logic greset_o, gpulse_o, run_mode_o;
    logic [5:0] reg_addr_o, pulse_width_o;
    logic [15:0] wr_data_o;
    logic [4:0] flip_count_o;

    ev_t exp_q[$];
    int checks = 0, failures = 0, n_seen = 0, plen = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cmd_decoder_tmr i_cmd_decoder_tmr (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .chip_id_i(chip_id_i),
        .trig_o(trig_o), .trig_flip_o(trig_flip_o), .bcr_o(bcr_o),
        .ecr_o(ecr_o), .cal_o(cal_o), .rd_o(rd_o), .wr_o(wr_o),
        .reg_addr_o(reg_addr_o), .wr_data_o(wr_data_o), .greset_o(greset_o),
        .gpulse_o(gpulse_o), .pulse_width_o(pulse_width_o),
        .run_mode_o(run_mode_o), .flip_count_o(flip_count_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push(input int k, input int a, input int d, input string req);
        ev_t e;
        e.kind = k; e.a = a; e.d = d; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic observe(input int k, input int a, input int d);
        ev_t e;
        n_seen++;
        checks++;
        if (exp_q.size() == 0) begin
            failures++;
            $display("FAIL R5 R10 R11 unexpected event actual=%0d/%0d/%0d expected=none", k, a, d);
        end else begin
            e = exp_q.pop_front();
            if (e.kind != k || e.a != a || e.d != d) begin
                failures++;
                $display("FAIL %s actual=%0d/%0d/%0d expected=%0d/%0d/%0d",
                         e.req, k, a, d, e.kind, e.a, e.d);
            end
        end
    endtask

    // Monitor: turns output activity into events at each falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (trig_o)   observe(K_TRIG, 0, int'(trig_flip_o));
            if (bcr_o)    observe(K_BCR, 0, 0);
            if (ecr_o)    observe(K_ECR, 0, 0);
            if (cal_o)    observe(K_CAL, 0, 0);
            if (rd_o)     observe(K_RD, int'(reg_addr_o), 0);
            if (wr_o)     observe(K_WR, int'(reg_addr_o), int'(wr_data_o));
            if (greset_o) observe(K_GRST, 0, 0);
            if (gpulse_o) plen++;
            else if (plen != 0) begin
                observe(K_PULSE, int'(pulse_width_o), plen);
                plen = 0;
            end
        end
    end

    task automatic send(input logic [63:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            cmd_i = v[i];
            @(negedge clk);
        end
        cmd_i = 1'b0;
    endtask

    task automatic send_slow(input logic [3:0] opc, input logic [3:0] id,
                             input logic [63:0] pl, input int n);
        send((64'({H_CMD, 4'b1000, opc, id}) << n) | pl, 17 + n);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic inject();
        force i_cmd_decoder_tmr.g_rep[1].u_reg.q_o = '0;
        @(negedge clk);
        release i_cmd_decoder_tmr.g_rep[1].u_reg.q_o;
        idle(3);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int seen;
        idle(4);
        // R1: idle state held by reset
        chk(run_mode_o == 1'b0, "R1 run mode", int'(run_mode_o), 0);
        chk(flip_count_o == 5'd0, "R1 flip count", int'(flip_count_o), 0);
        chk({trig_o, bcr_o, ecr_o, cal_o, rd_o, wr_o, greset_o, gpulse_o} == 8'd0,
            "R1 strobes", int'({trig_o, bcr_o, ecr_o, cal_o, rd_o, wr_o, greset_o, gpulse_o}), 0);
        rst_n = 1'b1;
        idle(2);

        // R5: run mode off, trigger and fast commands dropped
        seen = n_seen;
        send(64'(H_TRIG), 5); idle(2);
        send(64'({H_CMD, 4'b0001}), 9); idle(3);
        chk(n_seen == seen, "R5 ignored while stopped", n_seen - seen, 0);

        // R6: enable data taking with local ID
        send_slow(4'b1010, MY_ID, 64'd0, 0); idle(1);
        chk(run_mode_o == 1'b1, "R6 run mode set", int'(run_mode_o), 1);

        // R2: exact trigger
        push(K_TRIG, 0, 0, "R2 trigger"); send(64'(H_TRIG), 5); idle(2);
        // R3: each single flip in the four trailing bits
        for (int b = 0; b < 4; b++) begin
            push(K_TRIG, 0, 1, "R3 flipped trigger");
            send(64'(H_TRIG ^ (5'b00001 << b)), 5); idle(1);
        end
        // R4: fast commands
        push(K_BCR, 0, 0, "R4 bcr"); send(64'({H_CMD, 4'b0001}), 9);
        push(K_ECR, 0, 0, "R4 ecr"); send(64'({H_CMD, 4'b0010}), 9);
        push(K_CAL, 0, 0, "R4 cal"); send(64'({H_CMD, 4'b0100}), 9); idle(2);

        // R11: invalid header, fast field and opcode, each followed at once by a trigger
        seen = n_seen;
        send(64'(5'b10000), 5);
        send(64'({H_CMD, 4'b0011}), 9);
        send(64'({H_CMD, 4'b1000, 4'b0011}), 13);
        chk(n_seen == seen, "R11 invalid dropped", n_seen - seen, 0);
        push(K_TRIG, 0, 0, "R11 recovery"); send(64'(H_TRIG), 5); idle(2);

        // R7: read
        push(K_RD, 42, 0, "R7 read"); send_slow(4'b0001, MY_ID, 64'd42, 6); idle(2);
        // R8: write with broadcast ID
        push(K_WR, 21, 16'hBEEF, "R8 write");
        send_slow(4'b0010, 4'b1010, {42'd0, 6'd21, 16'hBEEF}, 22); idle(2);

        // R10: foreign ID, payload holds the trigger pattern
        seen = n_seen;
        send_slow(4'b0010, 4'h3, {42'd0, 6'd7, 16'hE8E8}, 22);
        send_slow(4'b0001, 4'h4, 64'd9, 6);
        chk(n_seen == seen, "R10 foreign ID dropped", n_seen - seen, 0);
        push(K_TRIG, 0, 0, "R10 next command"); send(64'(H_TRIG), 5); idle(2);

        // R9: pulse widths 0, 5 and 63
        push(K_PULSE, 0, 1, "R9 width 0");   send_slow(4'b1001, MY_ID, 64'd0, 6);  idle(5);
        push(K_PULSE, 5, 6, "R9 width 5");   send_slow(4'b1001, MY_ID, 64'd5, 6);  idle(10);
        push(K_PULSE, 63, 64, "R9 width 63"); send_slow(4'b1001, MY_ID, 64'd63, 6); idle(70);

        // R12: corrupt one replica
        inject();
        chk(flip_count_o != 5'd0, "R12 disagreement counted", int'(flip_count_o), 1);
        chk(run_mode_o == 1'b1, "R12 outvoted replica", int'(run_mode_o), 1);
        push(K_TRIG, 0, 0, "R12 still decoding"); send(64'(H_TRIG), 5); idle(2);
        for (int i = 0; i < 40; i++) inject();
        chk(flip_count_o == 5'd31, "R12 saturation", int'(flip_count_o), 31);

        // R6: global reset with broadcast ID clears run mode
        push(K_GRST, 0, 0, "R6 global reset"); send_slow(4'b1000, 4'b1111, 64'd0, 0);
        chk(run_mode_o == 1'b0, "R6 run mode cleared", int'(run_mode_o), 0);
        idle(2);
        seen = n_seen;
        send(64'(H_TRIG), 5); idle(3);
        chk(n_seen == seen, "R5 trigger after reset dropped", n_seen - seen, 0);

        // R13 and all: every queued event was produced
        chk(exp_q.size() == 0, "R13 pending events", exp_q.size(), 0);
        finish_run();
    end
endmodule